// File: doc/BRIEF.md
# Masked Time-Slot HDLC Frame Transmitter

This block turns bytes from a transmit FIFO into an HDLC bit stream. The stream goes out only on chosen bit positions of one time slot in a framed serial stream. Each frame starts with a flag. The payload bytes follow, least significant bit first. Then come a 16-bit frame check sequence and a closing flag. Inside the payload and the check field, a zero is inserted after every run of five ones. While nothing is queued, flags are sent back to back as idle fill.

The serializer has no bit clock of its own. In a given cycle, a bit position is an opportunity when the slot strobe is high and the channel mask selects the current bit position. On an opportunity the block drives one bit and raises `tx_valid`. On every other cycle it holds its state and leaves the position alone. A mask with one to eight bits set gives a channel of one to eight bits per frame.

The FIFO is read ahead: `fifo_data` and `fifo_eof` are valid while `fifo_empty` is low, and a one-cycle `fifo_rd_en` removes the entry. If the FIFO is empty when a byte that is not the last one has finished, the frame is aborted. The abort is a run of ones, and `underrun` pulses.

Top module: `hdlc_slot_tx`

## Requirements
- R1: `tx_valid` is high exactly in the cycles where `slot_strobe` is high and `chan_mask[bit_pos]` is 1. The block emits no bit in any other cycle, and its state advances only on such opportunities.
- R2: With the FIFO empty and no frame in progress, the output is a continuous run of flags 0x7E, sent LSB first as the bit sequence 0,1,1,1,1,1,1,0.
- R3: A frame is sent in this order: opening flag, payload bytes LSB first, 16-bit check sequence, closing flag. The byte whose `fifo_eof` is 1 is the last payload byte.
- R4: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408). It is computed over the unstuffed payload bits with the register preset to 0xFFFF. The ones-complement of the register is sent, bit 0 first.
- R5: After five consecutive 1s in the payload or the check field, a 0 is inserted before the next bit. This includes the position just before the closing flag. Flags are never stuffed.
- R6: `fifo_rd_en` pulses for one cycle, only on an opportunity with `fifo_empty` low, and exactly once per payload byte. The first pop happens on the last bit of the flag that opens the frame.
- R7: If the FIFO is empty when a byte that is not the last one has finished, the frame is abandoned and eight 1s are sent. `underrun` is then high for exactly one cycle, and flag idle fill resumes.
- R8: During and after reset, `fifo_rd_en` and `underrun` are low. The first bit sent after reset is bit 0 of a flag.
- R9: The transmitted bit sequence does not depend on which mask bits are set or how many.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_eof | input | 1 | Head byte is the last of its frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd_en | output | 1 | Pop the head byte |
| slot_strobe | input | 1 | Current bit belongs to this channel's time slot |
| bit_pos | input | 3 | Bit position within the time slot |
| chan_mask | input | 8 | Bit positions the channel may use |
| tx_bit | output | 1 | Transmitted bit, valid with tx_valid |
| tx_valid | output | 1 | This position carries a channel bit |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
Several conditions are hard to reach from the ports. The first is a zero that must be inserted across a byte boundary, or between the check field and the closing flag. The second is a FIFO that empties in the middle of a frame. The stimulus includes all-ones payloads and payloads that run through the flag pattern, so long runs of ones cross byte edges and the field boundaries. A frame is also queued without its end marker, which forces the abort path. The same expected stream is checked under sparse, dense and scattered masks, so stuffing and framing are shown to be independent of the channel rate.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  // one step of the reflected CRC-16 register for one serial bit
  function automatic logic [15:0] crc16_bit_step(input logic [15:0] crc,
                                                 input logic        din,
                                                 input logic [15:0] poly_rev);
    logic fb;
    fb = crc[0] ^ din;
    return (crc >> 1) ^ (fb ? poly_rev : 16'h0000);
  endfunction

  // next value of the consecutive-ones run counter
  function automatic logic [3:0] ones_next(input logic [3:0] run, input logic b);
    return b ? run + 4'd1 : 4'd0;
  endfunction

endpackage

// File: rtl/hdlc_slot_gate.sv
module hdlc_slot_gate #(
  parameter int SLOT_BITS = 8,
  parameter int POS_W     = 3
) (
  input  logic                 slot_strobe,
  input  logic [POS_W-1:0]     bit_pos,
  input  logic [SLOT_BITS-1:0] chan_mask,
  output logic                 take
);

  logic [SLOT_BITS-1:0] hit;

  generate
    for (genvar g = 0; g < SLOT_BITS; g++) begin : g_pos
      assign hit[g] = chan_mask[g] && (bit_pos == POS_W'(g));
    end
  endgenerate

  assign take = slot_strobe && (|hit);

endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] PRESET   = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        adv,
  input  logic        din,
  output logic [15:0] crc_q
);
  import hdlc_tx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= PRESET;
    else if (init) crc_q <= PRESET;
    else if (adv)  crc_q <= crc16_bit_step(crc_q, din, POLY_REV);
  end

endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm #(
  parameter logic [7:0] FLAG_PAT  = 8'h7E,
  parameter int         STUFF_RUN = 5,
  parameter int         ABORT_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  fifo_data,
  input  logic        fifo_eof,
  input  logic        fifo_empty,
  input  logic [15:0] crc_q,
  output logic        fifo_rd_en,
  output logic        tx_bit,
  output logic        crc_init,
  output logic        crc_adv,
  output logic        crc_din,
  output logic        underrun,
  output logic        stuff_now,
  output logic        in_body
);
  import hdlc_tx_pkg::*;

  localparam int AB_W  = (ABORT_LEN > 1) ? $clog2(ABORT_LEN) : 1;
  localparam int IDX_W = (AB_W > 4) ? AB_W : 4;

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       ones_q;
  logic [7:0]       byte_q;
  logic             last_q;
  logic             underrun_q;

  logic bit_sel, cur_bit, adv, at_byte_end, flag_end, byte_end, load, underrun_d;

  always_comb begin
    unique case (state_q)
      ST_FLAG:  bit_sel = FLAG_PAT[idx_q[2:0]];
      ST_DATA:  bit_sel = byte_q[idx_q[2:0]];
      ST_FCS:   bit_sel = ~crc_q[idx_q[3:0]];
      default:  bit_sel = 1'b1;
    endcase
  end

  assign stuff_now   = (ones_q == 4'(STUFF_RUN)) && (state_q != ST_ABORT);
  assign cur_bit     = stuff_now ? 1'b0 : bit_sel;
  assign adv         = take && !stuff_now;
  assign at_byte_end = (idx_q == IDX_W'(7));
  assign flag_end    = adv && (state_q == ST_FLAG) && at_byte_end;
  assign byte_end    = adv && (state_q == ST_DATA) && at_byte_end;
  assign load        = (flag_end || (byte_end && !last_q)) && !fifo_empty;
  assign underrun_d  = byte_end && !last_q && fifo_empty;

  assign fifo_rd_en = load;
  assign crc_init   = flag_end && !fifo_empty;
  assign crc_adv    = adv && (state_q == ST_DATA);
  assign crc_din    = byte_q[idx_q[2:0]];
  assign tx_bit     = cur_bit;
  assign underrun   = underrun_q;
  assign in_body    = (state_q == ST_DATA) || (state_q == ST_FCS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_FLAG;
      idx_q      <= '0;
      ones_q     <= '0;
      byte_q     <= '0;
      last_q     <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= underrun_d;
      if (take) begin
        if (stuff_now) begin
          ones_q <= '0;
        end else begin
          unique case (state_q)
            ST_FLAG: begin
              ones_q <= '0;
              if (at_byte_end) begin
                idx_q <= '0;
                if (!fifo_empty) begin
                  state_q <= ST_DATA;
                  byte_q  <= fifo_data;
                  last_q  <= fifo_eof;
                end
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            ST_DATA: begin
              ones_q <= ones_next(ones_q, cur_bit);
              if (at_byte_end) begin
                idx_q <= '0;
                if (last_q) begin
                  state_q <= ST_FCS;
                end else if (!fifo_empty) begin
                  byte_q <= fifo_data;
                  last_q <= fifo_eof;
                end else begin
                  state_q <= ST_ABORT;
                  ones_q  <= '0;
                end
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            ST_FCS: begin
              ones_q <= ones_next(ones_q, cur_bit);
              if (idx_q == IDX_W'(15)) begin
                state_q <= ST_FLAG;
                idx_q   <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            default: begin
              ones_q <= '0;
              if (idx_q == IDX_W'(ABORT_LEN - 1)) begin
                state_q <= ST_FLAG;
                idx_q   <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_slot_tx.sv
module hdlc_slot_tx #(
  parameter int          SLOT_BITS = 8,
  parameter logic [7:0]  FLAG_PAT  = 8'h7E,
  parameter int          STUFF_RUN = 5,
  parameter int          ABORT_LEN = 8,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  localparam int         POS_W     = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           fifo_data,
  input  logic                 fifo_eof,
  input  logic                 fifo_empty,
  output logic                 fifo_rd_en,
  input  logic                 slot_strobe,
  input  logic [POS_W-1:0]     bit_pos,
  input  logic [SLOT_BITS-1:0] chan_mask,
  output logic                 tx_bit,
  output logic                 tx_valid,
  output logic                 underrun
);

  logic        take;
  logic        crc_init, crc_adv, crc_din;
  logic [15:0] crc_q;
  logic        stuff_now, in_body;

  hdlc_slot_gate #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_gate (
    .slot_strobe (slot_strobe),
    .bit_pos     (bit_pos),
    .chan_mask   (chan_mask),
    .take        (take)
  );

  hdlc_crc16 #(.POLY_REV(CRC_POLY), .PRESET(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .adv   (crc_adv),
    .din   (crc_din),
    .crc_q (crc_q)
  );

  hdlc_tx_fsm #(.FLAG_PAT(FLAG_PAT), .STUFF_RUN(STUFF_RUN), .ABORT_LEN(ABORT_LEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .fifo_data  (fifo_data),
    .fifo_eof   (fifo_eof),
    .fifo_empty (fifo_empty),
    .crc_q      (crc_q),
    .fifo_rd_en (fifo_rd_en),
    .tx_bit     (tx_bit),
    .crc_init   (crc_init),
    .crc_adv    (crc_adv),
    .crc_din    (crc_din),
    .underrun   (underrun),
    .stuff_now  (stuff_now),
    .in_body    (in_body)
  );

  assign tx_valid = take;

endmodule

// File: rtl/hdlc_slot_tx_chk.sv
module hdlc_slot_tx_chk #(
  parameter int SLOT_BITS = 8,
  parameter int STUFF_RUN = 5,
  parameter int POS_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slot_strobe,
  input logic [POS_W-1:0]     bit_pos,
  input logic [SLOT_BITS-1:0] chan_mask,
  input logic                 fifo_empty,
  input logic                 fifo_rd_en,
  input logic                 tx_valid,
  input logic                 tx_bit,
  input logic                 underrun,
  input logic                 in_body,
  input logic                 stuff_now
);

  // run of ones seen on the output inside the stuffable region
  logic [3:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                run_q <= '0;
    else if (tx_valid && (in_body || stuff_now)) run_q <= tx_bit ? run_q + 4'd1 : 4'd0;
    else if (tx_valid)                          run_q <= '0;
  end

  p_no_strobe_no_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_strobe |-> !tx_valid);

  p_bit_on_masked_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> chan_mask[bit_pos]);

  p_run_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 4'(STUFF_RUN));

  p_zero_after_five_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && run_q == 4'(STUFF_RUN)) |-> !tx_bit);

  p_pop_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (!fifo_empty && tx_valid));

  p_underrun_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(fifo_empty) && $past(tx_valid)));

endmodule

bind hdlc_slot_tx hdlc_slot_tx_chk #(
  .SLOT_BITS(SLOT_BITS), .STUFF_RUN(STUFF_RUN), .POS_W(POS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_strobe (slot_strobe),
  .bit_pos     (bit_pos),
  .chan_mask   (chan_mask),
  .fifo_empty  (fifo_empty),
  .fifo_rd_en  (fifo_rd_en),
  .tx_valid    (tx_valid),
  .tx_bit      (tx_bit),
  .underrun    (underrun),
  .in_body     (in_body),
  .stuff_now   (stuff_now)
);

// File: tb/hdlc_slot_tx_tb.sv
module hdlc_slot_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_strobe = 1'b0;
  logic [2:0] bit_pos = '0;
  logic [7:0] chan_mask = 8'hFF;
  logic       fifo_rd_en, tx_bit, tx_valid, underrun;
  logic       fifo_empty, fifo_eof;
  logic [7:0] fifo_data;

  always #5 clk = ~clk;

  // bench FIFO model
  logic [8:0] qmem [0:255];
  logic [7:0] wr_p = '0;
  logic [7:0] rd_p = '0;
  assign fifo_empty = (wr_p == rd_p);
  assign fifo_data  = qmem[rd_p][7:0];
  assign fifo_eof   = qmem[rd_p][8];
  always @(posedge clk) if (fifo_rd_en) rd_p <= rd_p + 8'd1;

  hdlc_slot_tx u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en), .slot_strobe(slot_strobe),
    .bit_pos(bit_pos), .chan_mask(chan_mask), .tx_bit(tx_bit),
    .tx_valid(tx_valid), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  // framed stream: 4 slots of 8 bits, this channel owns slot 1
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      bit_pos     = 3'(cyc % 8);
      slot_strobe = ((cyc / 8) % 4) == 1;
      cyc++;
    end
  end

  // capture at the falling edge
  logic cap [0:4095];
  int   cap_n = 0, start_ix = 0, pops = 0, und_cnt = 0, gate_err = 0, rst_bad = 0;
  bit   started = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      if (fifo_rd_en || underrun) rst_bad++;
    end else begin
      if (tx_valid !== (slot_strobe && chan_mask[bit_pos])) gate_err++;
      if (underrun) und_cnt++;
      if (tx_valid) begin
        if (fifo_rd_en) begin
          pops++;
          if (!started) begin start_ix = cap_n; started = 1; end
        end
        if (cap_n < 4096) cap[cap_n] = tx_bit;
        cap_n++;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // expected stream
  logic exp_b [0:4095];
  int   exp_n = 0, run = 0;

  task automatic put_raw(input logic b);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic put_stuffed(input logic b);
    put_raw(b);
    run = b ? run + 1 : 0;
    if (run == 5) begin put_raw(1'b0); run = 0; end
  endtask

  task automatic put_flag();
    for (int i = 0; i < 8; i++) put_raw((i == 0 || i == 7) ? 1'b0 : 1'b1);
  endtask

  // queue a frame and build what must follow the opening flag
  task automatic queue_frame(input int len, input logic [7:0] base, input logic [7:0] step,
                             input bit with_eof);
    logic [15:0] crc;
    logic [7:0]  b;
    crc = 16'hFFFF; exp_n = 0; run = 0;
    for (int i = 0; i < len; i++) begin
      b = base + 8'(i) * step;
      qmem[wr_p] = {(with_eof && i == len - 1), b};
      crc = crc ^ {8'h00, b};
      for (int k = 0; k < 8; k++) crc = crc[0] ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
      for (int k = 0; k < 8; k++) put_stuffed(b[k]);
      wr_p = wr_p + 8'd1;
    end
    if (with_eof) begin
      crc = ~crc;
      for (int k = 0; k < 16; k++) put_stuffed(crc[k]);
      put_flag();
    end else begin
      for (int k = 0; k < 8; k++) put_raw(1'b1);
      put_flag();
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic compare_stream(input string req);
    int bad = -1;
    while (!(started && cap_n >= start_ix + 1 + exp_n)) @(negedge clk);
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && cap[start_ix + 1 + i] !== exp_b[i]) bad = i;
    check(bad < 0, req, "bit stream mismatch at index (actual=bit index, expected=-1)", bad, -1);
  endtask

  // mask, length, first byte, byte step
  localparam logic [31:0] VEC [5] = '{
    {8'hFF, 8'd1, 8'h00, 8'h00},
    {8'h01, 8'd3, 8'hFF, 8'h00},
    {8'hA5, 8'd4, 8'h7E, 8'h11},
    {8'h80, 8'd2, 8'h3C, 8'hC3},
    {8'h0F, 8'd6, 8'hF8, 8'h01}
  };

  initial begin
    logic [31:0] v;
    repeat (6) @(posedge clk);
    #2;
    @(negedge clk);
    check(!fifo_rd_en && !underrun, "R8", "outputs in reset", {fifo_rd_en, underrun}, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R2/R8: idle flags aligned to bit 0 after reset
    while (cap_n < 16) @(negedge clk);
    begin
      int bad = -1;
      for (int i = 0; i < 16; i++)
        if (bad < 0 && cap[i] !== (((i % 8) == 0 || (i % 8) == 7) ? 1'b0 : 1'b1)) bad = i;
      check(bad < 0, "R2", "idle flag fill from reset (actual=bad index)", bad, -1);
    end
    check(rst_bad == 0 && pops == 0 && und_cnt == 0, "R8", "no pop or underrun while idle",
          rst_bad + pops + und_cnt, 0);

    // table of frames: R3 R4 R5 R6 R9
    for (int t = 0; t < 5; t++) begin
      v = VEC[t];
      chan_mask = v[31:24];
      @(negedge clk);
      cap_n = 0; started = 0; pops = 0;
      queue_frame(int'(v[23:16]), v[15:8], v[7:0], 1'b1);
      compare_stream("R3/R4/R5/R9");
      check(pops == int'(v[23:16]), "R6", "pops per frame", pops, int'(v[23:16]));
    end

    // R7: FIFO runs dry mid frame
    chan_mask = 8'h3C;
    @(negedge clk);
    cap_n = 0; started = 0; pops = 0; und_cnt = 0;
    queue_frame(2, 8'h12, 8'h22, 1'b0);
    compare_stream("R7");
    check(und_cnt == 1, "R7", "underrun pulses", und_cnt, 1);
    check(pops == 2, "R7", "pops before abort", pops, 2);

    check(gate_err == 0, "R1", "tx_valid vs strobe and mask", gate_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule